// File: doc/BRIEF.md
# Posted Write Burst Disconnect Controller

This block sits beside the target state machine of a bus bridge that accepts memory write and memory write-and-invalidate (MWI) bursts into a posted write queue. On every accepted data phase it looks at the dword address of that phase, the burst's command, the window the burst decoded to, the cache line size setting and the queue's free-entry count. From these it decides whether the target must stop the burst after this phase. It returns a registered stop request together with a code that says which rule fired.

The block follows one burst at a time. The command, the upstream-window flag and the window's page size code are taken from the first data phase and held until the next first phase. After a stop has been requested, later phases of the same burst are ignored. The queue storage, address decoding and the bus handshake pins are outside the block.

Top module: `pw_disconnect`

## Requirements
- R1: After reset, `disc_o` is 0 and `reason_o` is 0, and no burst is open.
- R2: The stop request is registered. It is 1 in the clock cycle after the accepted data phase that triggers it, and only in that cycle. `reason_o` is 0 (none) whenever `disc_o` is 0. The reason codes are: 1 = queue full, 2 = 4 KB boundary, 3 = page boundary, 4 = cache line boundary.
- R3: If `free_cnt_i` is 1 or less when a phase is accepted, a stop with reason 1 follows. This holds for either command and for any address.
- R4: A phase whose address has its low 10 dword-address bits all ones (the next dword starts a new 4 KB block) is stopped with reason 2.
- R5: If the burst's latched window flag is 1, a phase whose address is the last dword of an aligned page is stopped with reason 3. The page holds 2^(4+s) dwords, where s is the latched `page_sel_i`.
- R6: For a plain write (`cmd_mwi_i` = 0), a phase at the last dword of a cache line is stopped with reason 4 only when `cl_disc_en_i` is 1.
- R7: For an MWI (`cmd_mwi_i` = 1), a phase at the last dword of a cache line is stopped with reason 4 when `free_cnt_i` is no larger than the cache line size, whatever the value of `cl_disc_en_i`.
- R8: The cache line size is valid only at 8, 16 or 32 dwords. Any other value of `cls_i` turns off both cache-line rules (R6 and R7).
- R9: When several rules hold in the same phase, the reported reason follows this priority: queue full, then 4 KB, then page, then cache line.
- R10: The command, the window flag and the page size code are sampled on the first data phase (`beat_first_i` = 1). Changes to them on later phases of the same burst have no effect.
- R11: A phase with `beat_first_i` = 0 is ignored in two cases: while no burst is open, and after a stop has been requested for the current burst. An ignored phase never produces a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised inside the block |
| beat_vld_i | input | 1 | A data phase is accepted in this cycle |
| beat_first_i | input | 1 | This phase is the first of a new burst |
| addr_i | input | ADDR_W | Dword address of this phase |
| cmd_mwi_i | input | 1 | 1 = MWI, 0 = plain memory write (sampled on the first phase) |
| up_win_i | input | 1 | Burst falls in the upstream secondary window (sampled on the first phase) |
| page_sel_i | input | PSEL_W | Page size code of that window, 2^(4+code) dwords (sampled on the first phase) |
| cls_i | input | 8 | Cache line size setting in dwords |
| cl_disc_en_i | input | 1 | Enables the cache line stop for plain writes |
| free_cnt_i | input | FREE_W | Free queue entries before this phase is written |
| disc_o | output | 1 | Registered stop request |
| reason_o | output | 3 | Registered reason code |

## Verification
The bench builds the block with its default parameters: a 30-bit dword address, an 8-entry page size code and a free count of up to 64 entries. With these values a sweep of addresses around a 4 KB seam reaches every rule. The sweep crosses both commands, both window states, both enable settings, three page codes and five cache line settings (the three valid sizes, one invalid non-zero size and zero). Free counts come from an arithmetic pattern, so the full, short-of-a-line and roomy cases all occur at line ends and at the 4 KB seam, and the priority between rules is tested wherever they overlap. Directed bursts cover the rest: the registered timing, attribute latching, and phases that are ignored while idle or after a stop.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

  // Reason reported with a stop request.
  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_QFULL = 3'd1,
    RSN_4K    = 3'd2,
    RSN_PAGE  = 3'd3,
    RSN_LINE  = 3'd4
  } reason_e;

  // Burst tracking state.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2
  } burst_st_e;

  // Width of the cache line size setting.
  localparam int CLS_W = 8;

  // Boundary flags collected for one data phase.
  typedef struct packed {
    logic end_4k;
    logic end_page;
    logic end_line;
  } bound_t;

endpackage

// File: rtl/pwd_cls_decode.sv
module pwd_cls_decode
  import pwd_pkg::*;
#(
  parameter int ADDR_W        = 30,
  parameter int LINE_MIN_LOG2 = 3,
  parameter int N_SIZES       = 3
) (
  input  logic [CLS_W-1:0]  cls_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] mask_o
);

  logic [N_SIZES-1:0]             match;
  logic [N_SIZES-1:0][ADDR_W-1:0] size_mask;

  // One comparator per supported line size.
  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    localparam int SZ = 1 << (LINE_MIN_LOG2 + g);
    assign match[g]     = (cls_i == CLS_W'(SZ));
    assign size_mask[g] = ADDR_W'(SZ - 1);
  end

  always_comb begin
    mask_o = '0;
    for (int i = 0; i < N_SIZES; i++) begin
      if (match[i]) mask_o = mask_o | size_mask[i];
    end
  end

  assign valid_o = |match;

endmodule

// File: rtl/pwd_bound_detect.sv
module pwd_bound_detect
  import pwd_pkg::*;
#(
  parameter int ADDR_W        = 30,
  parameter int KB4_LOG2      = 10,
  parameter int PSEL_W        = 3,
  parameter int PAGE_MIN_LOG2 = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              win_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic              line_ok_i,
  input  logic [ADDR_W-1:0] line_mask_i,
  output bound_t            bound_o
);

  localparam int N_PAGE = 1 << PSEL_W;

  logic [N_PAGE-1:0] pg_end;

  // Last-dword detector for each selectable page size.
  for (genvar g = 0; g < N_PAGE; g++) begin : g_page
    localparam int LG = PAGE_MIN_LOG2 + g;
    assign pg_end[g] = &addr_i[LG-1:0];
  end

  always_comb begin
    bound_o.end_4k   = &addr_i[KB4_LOG2-1:0];
    bound_o.end_page = win_i & pg_end[psel_i];
    bound_o.end_line = line_ok_i & ((addr_i & line_mask_i) == line_mask_i);
  end

endmodule

// File: rtl/pwd_rule_arb.sv
module pwd_rule_arb
  import pwd_pkg::*;
#(
  parameter int FREE_W = 7
) (
  input  bound_t            bound_i,
  input  logic              mwi_i,
  input  logic              cl_en_i,
  input  logic [FREE_W-1:0] free_i,
  input  logic [CLS_W-1:0]  cls_i,
  output reason_e           reason_o
);

  localparam int CMP_W = (FREE_W > CLS_W) ? FREE_W : CLS_W;

  logic [CMP_W-1:0] free_ext;
  logic [CMP_W-1:0] cls_ext;
  logic             qfull;
  logic             short_line;
  logic             line_rule;

  assign free_ext   = CMP_W'(free_i);
  assign cls_ext    = CMP_W'(cls_i);
  assign qfull      = (free_i <= FREE_W'(1));
  assign short_line = (free_ext <= cls_ext);

  // Plain writes honour the enable; MWI watches remaining space instead.
  assign line_rule = bound_i.end_line & (mwi_i ? short_line : cl_en_i);

  always_comb begin
    if (qfull)                 reason_o = RSN_QFULL;
    else if (bound_i.end_4k)   reason_o = RSN_4K;
    else if (bound_i.end_page) reason_o = RSN_PAGE;
    else if (line_rule)        reason_o = RSN_LINE;
    else                       reason_o = RSN_NONE;
  end

endmodule

// File: rtl/pwd_burst_ctl.sv
module pwd_burst_ctl
  import pwd_pkg::*;
#(
  parameter int PSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld_i,
  input  logic              beat_first_i,
  input  logic              cmd_mwi_i,
  input  logic              up_win_i,
  input  logic [PSEL_W-1:0] page_sel_i,
  input  logic              hit_i,
  output logic              accept_o,
  output logic              eff_mwi_o,
  output logic              eff_win_o,
  output logic [PSEL_W-1:0] eff_psel_o,
  output logic              att_mwi_o,
  output burst_st_e         st_o
);

  burst_st_e         st_q, st_d;
  logic              mwi_q, mwi_d;
  logic              win_q, win_d;
  logic [PSEL_W-1:0] psel_q, psel_d;
  logic              load;

  assign load     = beat_vld_i & beat_first_i;
  assign accept_o = beat_vld_i & (beat_first_i | (st_q == ST_RUN));

  // First phase uses its own attributes; later phases use the held copy.
  assign eff_mwi_o  = beat_first_i ? cmd_mwi_i  : mwi_q;
  assign eff_win_o  = beat_first_i ? up_win_i   : win_q;
  assign eff_psel_o = beat_first_i ? page_sel_i : psel_q;

  always_comb begin
    st_d = st_q;
    if (accept_o) begin
      st_d = hit_i ? ST_STOP : ST_RUN;
    end
  end

  always_comb begin
    mwi_d  = mwi_q;
    win_d  = win_q;
    psel_d = psel_q;
    if (load) begin
      mwi_d  = cmd_mwi_i;
      win_d  = up_win_i;
      psel_d = page_sel_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mwi_q  <= 1'b0;
      win_q  <= 1'b0;
      psel_q <= '0;
    end else begin
      st_q   <= st_d;
      mwi_q  <= mwi_d;
      win_q  <= win_d;
      psel_q <= psel_d;
    end
  end

  assign att_mwi_o = mwi_q;
  assign st_o      = st_q;

endmodule

// File: rtl/pw_disconnect.sv
module pw_disconnect
  import pwd_pkg::*;
#(
  parameter int ADDR_W        = 30,
  parameter int KB4_LOG2      = 10,
  parameter int PSEL_W        = 3,
  parameter int PAGE_MIN_LOG2 = 4,
  parameter int LINE_MIN_LOG2 = 3,
  parameter int N_LINE_SIZES  = 3,
  parameter int QDEPTH        = 64,
  parameter int FREE_W        = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld_i,
  input  logic              beat_first_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cmd_mwi_i,
  input  logic              up_win_i,
  input  logic [PSEL_W-1:0] page_sel_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic              cl_disc_en_i,
  input  logic [FREE_W-1:0] free_cnt_i,
  output logic              disc_o,
  output logic [2:0]        reason_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic              line_ok;
  logic [ADDR_W-1:0] line_mask;
  bound_t            bound;
  reason_e           reason_c;
  logic              hit_c;
  logic              accept;
  logic              eff_mwi;
  logic              eff_win;
  logic [PSEL_W-1:0] eff_psel;
  logic              att_mwi;
  burst_st_e         burst_st;

  pwd_cls_decode #(
    .ADDR_W(ADDR_W), .LINE_MIN_LOG2(LINE_MIN_LOG2), .N_SIZES(N_LINE_SIZES)
  ) u_cls (
    .cls_i(cls_i), .valid_o(line_ok), .mask_o(line_mask)
  );

  pwd_bound_detect #(
    .ADDR_W(ADDR_W), .KB4_LOG2(KB4_LOG2), .PSEL_W(PSEL_W), .PAGE_MIN_LOG2(PAGE_MIN_LOG2)
  ) u_bound (
    .addr_i(addr_i), .win_i(eff_win), .psel_i(eff_psel),
    .line_ok_i(line_ok), .line_mask_i(line_mask), .bound_o(bound)
  );

  pwd_rule_arb #(.FREE_W(FREE_W)) u_arb (
    .bound_i(bound), .mwi_i(eff_mwi), .cl_en_i(cl_disc_en_i),
    .free_i(free_cnt_i), .cls_i(cls_i), .reason_o(reason_c)
  );

  assign hit_c = (reason_c != RSN_NONE);

  pwd_burst_ctl #(.PSEL_W(PSEL_W)) u_ctl (
    .clk(clk), .rst_n(rst_sync_n),
    .beat_vld_i(beat_vld_i), .beat_first_i(beat_first_i),
    .cmd_mwi_i(cmd_mwi_i), .up_win_i(up_win_i), .page_sel_i(page_sel_i),
    .hit_i(hit_c), .accept_o(accept),
    .eff_mwi_o(eff_mwi), .eff_win_o(eff_win), .eff_psel_o(eff_psel),
    .att_mwi_o(att_mwi), .st_o(burst_st)
  );

  // Output register: next-state logic, then flops.
  logic    disc_q, disc_d;
  reason_e reason_q, reason_d;

  always_comb begin
    disc_d   = 1'b0;
    reason_d = RSN_NONE;
    if (accept && hit_c) begin
      disc_d   = 1'b1;
      reason_d = reason_c;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      disc_q   <= 1'b0;
      reason_q <= RSN_NONE;
    end else begin
      disc_q   <= disc_d;
      reason_q <= reason_d;
    end
  end

  assign disc_o   = disc_q;
  assign reason_o = reason_q;

endmodule

// File: rtl/pwd_checker.sv
module pwd_checker
  import pwd_pkg::*;
#(
  parameter int ADDR_W   = 30,
  parameter int KB4_LOG2 = 10,
  parameter int FREE_W   = 7
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              beat_vld_i,
  input logic              beat_first_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CLS_W-1:0]  cls_i,
  input logic [FREE_W-1:0] free_cnt_i,
  input logic              disc_o,
  input logic [2:0]        reason_o,
  input logic [1:0]        burst_st,
  input logic              att_mwi
);

  logic cls_good;
  assign cls_good = (cls_i == CLS_W'(8)) || (cls_i == CLS_W'(16)) || (cls_i == CLS_W'(32));

  p_reason_idle_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !disc_o |-> reason_o == 3'd0);

  p_after_beat_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    disc_o |-> $past(beat_vld_i));

  p_qfull_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_vld_i && beat_first_i && free_cnt_i <= FREE_W'(1)
    |=> disc_o && reason_o == 3'd1);

  p_seam_4k_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_vld_i && beat_first_i && free_cnt_i > FREE_W'(1) && (&addr_i[KB4_LOG2-1:0])
    |=> disc_o && reason_o == 3'd2);

  p_bad_cls_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_vld_i && beat_first_i && !cls_good |=> reason_o != 3'd4);

  p_attr_hold_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(beat_vld_i && beat_first_i) |=> $stable(att_mwi));

  p_stop_ignore_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    beat_vld_i && !beat_first_i && burst_st == 2'd2 |=> !disc_o);

endmodule

bind pw_disconnect pwd_checker #(
  .ADDR_W(ADDR_W), .KB4_LOG2(KB4_LOG2), .FREE_W(FREE_W)
) u_pwd_checker (
  .clk(clk), .rst_sync_n(rst_sync_n), .beat_vld_i(beat_vld_i),
  .beat_first_i(beat_first_i), .addr_i(addr_i), .cls_i(cls_i),
  .free_cnt_i(free_cnt_i), .disc_o(disc_o), .reason_o(reason_o),
  .burst_st(burst_st), .att_mwi(att_mwi)
);

// File: tb/pw_disconnect_bench.sv
`timescale 1ns/1ps
module pw_disconnect_bench;

  localparam int ADDR_W = 30;
  localparam int PSEL_W = 3;
  localparam int FREE_W = 7;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              beat_vld, beat_first, mwi, win, clen;
  logic [ADDR_W-1:0] addr;
  logic [PSEL_W-1:0] psel;
  logic [7:0]        cls;
  logic [FREE_W-1:0] free;
  logic              disc;
  logic [2:0]        rsn;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pw_disconnect u_pw_disconnect (
    .clk(clk), .rst_n(rst_n), .beat_vld_i(beat_vld), .beat_first_i(beat_first),
    .addr_i(addr), .cmd_mwi_i(mwi), .up_win_i(win), .page_sel_i(psel),
    .cls_i(cls), .cl_disc_en_i(clen), .free_cnt_i(free),
    .disc_o(disc), .reason_o(rsn)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Expected reason, from the requirement text (R3..R9).
  function automatic int exp_rsn(longint a, bit m, bit w, int ps, int c, bit ce, int f);
    bit line_ok;
    longint pg;
    line_ok = (c == 8) || (c == 16) || (c == 32);
    pg = longint'(1) << (4 + ps);
    if (f <= 1) return 1;
    if ((a % 1024) == 1023) return 2;
    if (w && ((a % pg) == pg - 1)) return 3;
    if (line_ok && ((a % c) == c - 1) && (m ? (f <= c) : ce)) return 4;
    return 0;
  endfunction

  task automatic check(string tag, int exp_r);
    bit exp_d;
    exp_d = (exp_r != 0);
    checks++;
    if (disc !== exp_d || rsn !== 3'(exp_r)) begin
      failures++;
      $display("FAIL %s: actual disc=%0b reason=%0d expected disc=%0b reason=%0d",
               tag, disc, rsn, exp_d, exp_r);
    end
  endtask

  task automatic beat(bit f, longint a, bit m, bit w, int ps, int c, bit ce, int fr);
    beat_vld = 1'b1; beat_first = f; addr = ADDR_W'(a); mwi = m; win = w;
    psel = PSEL_W'(ps); cls = 8'(c); clen = ce; free = FREE_W'(fr);
    @(negedge clk);
  endtask

  task automatic idle_cycle();
    beat_vld = 1'b0; beat_first = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int cls_set[5];
    int ps_set[3];
    longint base;
    cls_set[0] = 8; cls_set[1] = 16; cls_set[2] = 32; cls_set[3] = 12; cls_set[4] = 0;
    ps_set[0] = 0; ps_set[1] = 2; ps_set[2] = 7;
    base = 30'h000A_BC00;

    rst_n = 1'b0; beat_vld = 0; beat_first = 0; addr = '0; mwi = 0; win = 0;
    psel = '0; cls = 8'd8; clen = 0; free = FREE_W'(20);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 reset", 0);

    // R11: a non-first phase with no open burst is ignored
    beat(0, 1023, 0, 0, 0, 8, 1, 20);
    check("R11 idle ignore", 0);

    // R2: registered output, one cycle per trigger; R6 plain write line stop
    beat(1, 5, 0, 0, 0, 8, 0, 20);
    check("R2 no trigger", 0);
    beat_vld = 1; beat_first = 0; addr = ADDR_W'(7); clen = 1'b1; free = FREE_W'(20);
    #2;
    check("R2 not combinational", 0);
    @(negedge clk);
    check("R6 line with enable", 4);
    idle_cycle();
    check("R2 single pulse", 0);

    // R11: after a stop, further phases of the burst are ignored
    beat(0, 1023, 0, 0, 0, 8, 1, 1);
    check("R11 stopped ignore", 0);

    // R10: command latched on first phase (plain, enable off)
    beat(1, 32'h100, 0, 0, 0, 8, 0, 30);
    check("R10 open plain", 0);
    beat(0, 32'h107, 1, 0, 0, 8, 0, 4);
    check("R10 later mwi ignored", 0);
    // R10: window flag latched
    beat(1, 32'h200, 0, 0, 0, 0, 0, 30);
    check("R10 open no window", 0);
    beat(0, 32'h20F, 0, 1, 0, 0, 0, 30);
    check("R10 later window ignored", 0);
    // R7/R10: MWI latched, later plain ignored, free <= line size
    beat(1, 32'h300, 1, 0, 0, 8, 0, 30);
    check("R7 open mwi", 0);
    beat(0, 32'h307, 0, 0, 0, 8, 0, 8);
    check("R7 mwi short line", 4);
    // R11: new first phase reopens after stop
    beat(1, 32'h3FF, 0, 0, 0, 8, 0, 30);
    check("R11 reopen R4 seam", 2);

    // Sweep: every phase opens its own burst (R3..R9)
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int ce = 0; ce < 2; ce++)
          for (int ci = 0; ci < 5; ci++)
            for (int pi = 0; pi < 3; pi++)
              for (int k = 0; k < 225; k++) begin
                longint a;
                int fr, e;
                a = base + 900 + k;
                fr = (k * 7 + ci * 3 + pi) % 40;
                e = exp_rsn(a, m[0], w[0], ps_set[pi], cls_set[ci], ce[0], fr);
                beat(1, a, m[0], w[0], ps_set[pi], cls_set[ci], ce[0], fr);
                case (e)
                  1: check("R3 queue full R9", e);
                  2: check("R4 4KB seam R9", e);
                  3: check("R5 page end R9", e);
                  4: check(m ? "R7 mwi line R8" : "R6 plain line R8", e);
                  default: check("R8 no stop", e);
                endcase
              end

    idle_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule